// File: doc/BRIEF.md
# Fast Ethernet Carrier Sense Detector

This block sits behind the clock-and-data recovery and descrambler of a 100 Mbit/s receiver. It watches the recovered serial bit stream, one bit per valid strobe, and produces the carrier sense signal for the MAC. Receive carrier comes up as soon as the recent bit history shows two zeros that are not neighbours. It goes down only when an aligned 5-bit code-group says the stream has ended.

While receive carrier is up, an external alignment strobe marks the bit that completes each 5-bit code-group. The block compares the group against the idle pattern and the two-group end-of-stream delimiter. When carrier ends, the bit history is wiped, so the closing frame cannot start a new carrier. The final output merges transmit activity when the link runs half duplex and ignores it when the link runs full duplex.

Top module: `fx_carrier_sense`

## Requirements
- R1: On a cycle with `bit_vld` high, if the ten most recent bits (the new bit included) hold two zeros with at least one bit between them, receive carrier is set and `crs` reads high from the following cycle.
- R2: Two adjacent zeros with no other zero nearby do not raise carrier, and neither do two zeros separated by nine or more ones (for example 0, nine 1s, 0).
- R3: While carrier is up, a `grp_strobe` together with `bit_vld` whose 5-bit group is 11111 drops carrier from the next cycle. The group is read oldest bit first, so the first received bit is the leftmost.
- R4: While carrier is up, group 01101 followed on the next strobed group by 00111 drops carrier. A 00111 group without a 01101 group just before it keeps carrier. So does a 01101 group followed by any other group.
- R5: On the cycle carrier drops, the bit history is set to all ones. A single zero received afterwards does not raise carrier again.
- R6: With `full_dup` low, `crs` is high in the same cycle whenever `tx_active` is high, regardless of receive carrier.
- R7: With `full_dup` high, `tx_active` has no effect, and `crs` equals receive carrier.
- R8: Receive carrier and the bit history change only on cycles with `bit_vld` high. `grp_strobe` has no effect while carrier is down.
- R9: A synchronous active-high `rst` clears receive carrier and sets the bit history to all ones. A single zero received after reset does not raise carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Recovered descrambled serial bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| grp_strobe | input | 1 | Marks the bit that completes a 5-bit code-group |
| tx_active | input | 1 | Transmit in progress |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | output | 1 | Carrier sense |

## Verification
The bench probes both edges of the window. A zero pair nine positions apart must raise carrier, and a pair ten positions apart must not. A design with a window that is one bit too short or too long flips one of these two outcomes. Adjacent zeros must not start carrier; a design that merely counts zeros would start it on them.

Stray delimiter halves are also tested. A 00111 group without a 01101 group before it must keep carrier, and so must a 01101 group followed by another group. A design that remembers a lone half of the delimiter, or ignores the order of the two groups, would drop carrier too early.

After each drop, a single zero is sent to catch a design that keeps the old history and retriggers. Transmit activity is applied under both duplex settings to catch a design that uses the wrong merge rule.

// File: rtl/fx_carrier_sense.sv
module fx_carrier_sense #(
  parameter int WIN = 10,
  parameter int GRP = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  input  logic grp_strobe,
  input  logic tx_active,
  input  logic full_dup,
  output logic crs
);
  localparam logic [GRP-1:0] IDLE_CG = '1;
  localparam logic [GRP-1:0] END_T   = 5'b01101;
  localparam logic [GRP-1:0] END_R   = 5'b00111;

  logic [WIN-1:0] win;
  logic           rx_car;
  logic           t_seen;
  logic           pair;

  wire [WIN-1:0] win_nx = {win[WIN-2:0], bit_in};
  wire [GRP-1:0] grp    = win_nx[GRP-1:0];
  wire           stop   = grp_strobe && (grp == IDLE_CG || (t_seen && grp == END_R));

  always_comb begin
    pair = 1'b0;
    for (int i = 0; i < WIN; i++)
      for (int j = i + 2; j < WIN; j++)
        if (!win_nx[i] && !win_nx[j]) pair = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_car <= 1'b0;
      win    <= '1;
      t_seen <= 1'b0;
    end else if (bit_vld) begin
      if (!rx_car) begin
        win    <= win_nx;
        t_seen <= 1'b0;
        if (pair) rx_car <= 1'b1;
      end else if (stop) begin
        rx_car <= 1'b0;
        win    <= '1;
        t_seen <= 1'b0;
      end else begin
        win <= win_nx;
        if (grp_strobe) t_seen <= (grp == END_T);
      end
    end
  end

  assign crs = rx_car | (tx_active & ~full_dup);
endmodule

module fx_carrier_sense_chk #(
  parameter int WIN = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           bit_in,
  input logic           bit_vld,
  input logic           grp_strobe,
  input logic           tx_active,
  input logic           full_dup,
  input logic           crs,
  input logic           rx_car,
  input logic [WIN-1:0] win
);
  // R1
  rise_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_car) |-> $past(bit_vld));
  // R3
  idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_car && bit_vld && grp_strobe && {win[3:0], bit_in} == 5'b11111) |=> !rx_car);
  // R5
  window_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_car) |-> (win == '1));
  // R6
  half_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_dup && tx_active) |-> crs);
  // R7
  full_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
    full_dup |-> (crs == rx_car));
  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> ($stable(rx_car) && $stable(win)));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_car && win == '1));
endmodule

bind fx_carrier_sense fx_carrier_sense_chk #(.WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
  .grp_strobe(grp_strobe), .tx_active(tx_active), .full_dup(full_dup),
  .crs(crs), .rx_car(rx_car), .win(win)
);

// File: tb/sim_fx_carrier_sense.sv
module sim_fx_carrier_sense;
  logic clk = 0, rst = 1, bit_in = 1, bit_vld = 0, grp_strobe = 0;
  logic tx_active = 0, full_dup = 0;
  logic crs;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  fx_carrier_sense u0 (.*);

  // {exp_crs, full_dup, tx_active, grp_strobe, bit_vld, bit_in}
  localparam logic [5:0] VEC [45] = '{
    6'b000011, 6'b000010, 6'b000010, 6'b000011, 6'b000011,
    6'b100010, 6'b100011, 6'b110000,
    6'b100010, 6'b100011, 6'b100011, 6'b100010, 6'b100111,
    6'b100011, 6'b100010, 6'b100011, 6'b100010, 6'b100111,
    6'b100010, 6'b100010, 6'b100011, 6'b100011, 6'b100111,
    6'b100010, 6'b100011, 6'b100011, 6'b100010, 6'b100111,
    6'b100010, 6'b100010, 6'b100011, 6'b100011, 6'b000111,
    6'b000010, 6'b000011, 6'b101000, 6'b011000, 6'b100010, 6'b111000,
    6'b100011, 6'b100011, 6'b100011, 6'b100011, 6'b000111,
    6'b000110
  };

  function automatic string tag_of(int k);
    if (k <= 4) return "R2";
    if (k <= 6) return "R1";
    if (k == 7) return "R7";
    if (k <= 32) return "R4";
    if (k <= 34) return "R5";
    if (k == 35) return "R6";
    if (k == 36 || k == 38) return "R7";
    if (k == 37) return "R1";
    if (k <= 43) return "R3";
    return "R8";
  endfunction

  task automatic check(string req, string what, logic exp);
    n_chk++;
    if (crs !== exp) begin
      n_bad++;
      $display("FAIL %s %s: crs=%b expected %b", req, what, crs, exp);
    end
  endtask

  task automatic step(logic b, logic v, logic g, logic t, logic f);
    @(negedge clk);
    bit_in = b; bit_vld = v; grp_strobe = g; tx_active = t; full_dup = f;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; bit_vld = 0; grp_strobe = 0; tx_active = 0; full_dup = 0;
    @(posedge clk);
    #1;
    rst = 0;
  endtask

  task automatic gap_test(int ones, logic exp, string req);
    do_reset();
    step(0, 1, 0, 0, 0);
    for (int i = 0; i < ones; i++) step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check(req, $sformatf("zeros %0d ones apart", ones), exp);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not end, crs=%b expected completion", crs);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R9", "state after reset", 0);

    for (int k = 0; k < 45; k++) begin
      step(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4]);
      check(tag_of(k), $sformatf("vector %0d", k), VEC[k][5]);
    end

    gap_test(8, 1, "R1");
    gap_test(9, 0, "R2");

    // R9: reset in mid carrier, then one zero must not retrigger
    do_reset();
    step(0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check("R1", "carrier before reset", 1);
    do_reset();
    check("R9", "reset drops carrier", 0);
    step(0, 1, 0, 0, 0);
    check("R9", "history cleared by reset", 0);

    // R8: idle pattern with strobe but no bit_vld keeps carrier
    step(1, 1, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    check("R1", "carrier up again", 1);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 0);
    check("R8", "strobe without bit_vld", 1);
    step(1, 1, 1, 0, 0);
    check("R3", "idle group ends carrier", 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule